// File: doc/BRIEF.md
# Two-Way Tag Store with Per-Way Parity

This block holds the tag state of a two-way set-associative cache. Every set keeps two 20-bit way entries and one LRU bit. Each way entry packs a 15-bit tag, a 4-bit line status field and a read-only flag. Each way entry has its own stored parity bit, written beside it. The LRU bit has no parity protection. A lookup reads the whole set, including both parity bits. A separate checker then recomputes parity from the data it read and compares it with the stored bits. When either way disagrees, it drives a registered, active-low error flag.

There are two ways to change a set. A full write replaces one way entry and stores fresh parity for it. A partial update changes only the bits chosen by a mask, for example a status-only change after a snoop or a move from exclusive to modified. A partial update runs as a two-cycle read-modify-write, so that the new parity always covers the complete merged entry. The block lowers `ready` during those two cycles, and while `ready` is low it ignores every request. A separate test input flips one stored bit without touching parity, which lets error detection be exercised.

Top module: `tag_store_2way`

## Requirements
- R1: While reset is held, `perr_n` is 1, `ready` is 1 and `rd_valid` is 0. After reset, every set reads back as all-zero entries and an LRU of 0, with no error.
- R2: A lookup accepted in a cycle drives `rd_valid` high for exactly the cycle after the next rising edge. In that cycle `rd_ent0`, `rd_ent1` and `rd_lru` hold the set's two way entries and its LRU bit. Entry layout: tag in [19:5], status in [4:1], read-only flag in [0].
- R3: A full write stores the entry in the selected way with even parity over its 20 bits. A later lookup returns that entry with `perr_n` high, and the other way is left unchanged.
- R4: When a lookup and a write to the same set happen in the same cycle, the lookup returns the set contents as they were before the write.
- R5: A partial update stores (old & ~mask) | (data & mask) into the selected way. The other way and the LRU bit are left unchanged.
- R6: After a partial update is accepted, `ready` is low for exactly the next two cycles and then returns high. Lookups, full writes, LRU writes and partial requests presented while `ready` is low are ignored.
- R7: `perr_n` goes low after a set read in which either way's stored parity disagrees with its data. It is held until the next set read, and it returns high after a clean read. The test flip selector picks bits 0–19 for entry bits, 20 for the way's parity bit and 21 for the set's LRU bit.
- R8: The LRU bit is outside parity coverage. Flipping it or rewriting it never lowers `perr_n`.
- R9: The read step of a partial update also checks parity and updates `perr_n`. The merged write then stores fresh parity, so a way that had a stored error reads back clean afterwards.
- R10: When a full write and a partial request arrive in the same ready cycle, the full write takes effect, the partial request is dropped, and `ready` stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ready | output | 1 | High when requests are accepted |
| lk_en | input | 1 | Lookup request |
| lk_idx | input | 4 | Lookup set index |
| wr_en | input | 1 | Full-entry write request |
| wr_idx | input | 4 | Full-write set index |
| wr_way | input | 1 | Full-write way select |
| wr_ent | input | 20 | Full-write entry value |
| lru_we | input | 1 | LRU bit write request |
| lru_idx | input | 4 | LRU write set index |
| lru_val | input | 1 | LRU value to store |
| pu_en | input | 1 | Partial update request |
| pu_idx | input | 4 | Partial update set index |
| pu_way | input | 1 | Partial update way select |
| pu_mask | input | 20 | Bits to replace |
| pu_data | input | 20 | Replacement bit values |
| tst_flip | input | 1 | Test: flip one stored bit |
| tst_idx | input | 4 | Test flip set index |
| tst_way | input | 1 | Test flip way select |
| tst_bit | input | 5 | Test flip bit: 0–19 entry, 20 parity, 21 LRU |
| rd_valid | output | 1 | Lookup result valid |
| rd_ent0 | output | 20 | Way 0 entry from the last lookup |
| rd_ent1 | output | 20 | Way 1 entry from the last lookup |
| rd_lru | output | 1 | LRU bit from the last lookup |
| perr_n | output | 1 | Active-low parity error flag |

## Verification
Lookups are tried three ways: against freshly reset sets, against distinct per-set entry patterns, and in the same cycle as a write to the same set. Together these separate correct addressing and way steering from a read that sees the new data too early. Partial updates are driven with a status-only mask, a read-only-flag mask and a mixed mask, which shows that untouched bits and the other way survive the merge. Single-bit flips in an entry bit, in the parity bit and in the LRU bit separate real parity detection from a checker that is too eager or that wrongly covers the LRU. A partial update of a corrupted way then shows that the read step reports the error and the merged write clears it.

// File: rtl/tagp_pkg.sv
package tagp_pkg;

  localparam int DEF_SETS   = 16;
  localparam int DEF_TAG_W  = 15;
  localparam int DEF_STAT_W = 4;

  typedef enum logic [1:0] {
    RMW_IDLE  = 2'd0,
    RMW_READ  = 2'd1,
    RMW_WRITE = 2'd2
  } rmw_st_e;

endpackage

// File: rtl/tag_parity_gen.sv
module tag_parity_gen #(
  parameter int W = 20
) (
  input  logic [W-1:0] data_i,
  output logic         par_o
);

  // Even parity: the data bits plus par_o have an even number of ones.
  assign par_o = ^data_i;

endmodule

// File: rtl/tag_set_array.sv
module tag_set_array #(
  parameter int SETS  = 16,
  parameter int ENT_W = 20,
  parameter int IDX_W = 4,
  parameter int SEL_W = 5
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [IDX_W-1:0]          rd_idx,
  output logic [1:0][ENT_W-1:0]     rd_ent,
  output logic [1:0]                rd_par,
  output logic                      rd_lru,
  input  logic                      we,
  input  logic [IDX_W-1:0]          w_idx,
  input  logic                      w_way,
  input  logic [ENT_W-1:0]          w_ent,
  input  logic                      w_par,
  input  logic                      lru_we,
  input  logic [IDX_W-1:0]          lru_idx,
  input  logic                      lru_val,
  input  logic                      flip_en,
  input  logic [IDX_W-1:0]          flip_idx,
  input  logic                      flip_way,
  input  logic [SEL_W-1:0]          flip_sel
);

  localparam logic [SEL_W-1:0] SEL_LRU = SEL_W'(ENT_W + 1);

  // Each way word keeps its parity bit at the top, right beside the entry.
  logic [1:0][ENT_W:0] way_q [SETS];
  logic [SETS-1:0]     lru_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) way_q[s] <= '0;
      lru_q <= '0;
    end else begin
      if (flip_en) begin
        if (flip_sel == SEL_LRU) lru_q[flip_idx] <= ~lru_q[flip_idx];
        else way_q[flip_idx][flip_way][flip_sel] <= ~way_q[flip_idx][flip_way][flip_sel];
      end
      if (we)     way_q[w_idx][w_way] <= {w_par, w_ent};
      if (lru_we) lru_q[lru_idx]      <= lru_val;
    end
  end

  for (genvar w = 0; w < 2; w++) begin : g_rd
    assign rd_ent[w] = way_q[rd_idx][w][ENT_W-1:0];
    assign rd_par[w] = way_q[rd_idx][w][ENT_W];
  end
  assign rd_lru = lru_q[rd_idx];

endmodule

// File: rtl/tag_rmw_ctrl.sv
module tag_rmw_ctrl
  import tagp_pkg::*;
#(
  parameter int IDX_W = 4,
  parameter int ENT_W = 20
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start_i,
  input  logic [IDX_W-1:0]      idx_i,
  input  logic                  way_i,
  input  logic [ENT_W-1:0]      mask_i,
  input  logic [ENT_W-1:0]      data_i,
  input  logic [1:0][ENT_W-1:0] old_ent_i,
  output logic                  busy_o,
  output logic                  rd_phase_o,
  output logic                  wr_phase_o,
  output logic [IDX_W-1:0]      idx_o,
  output logic                  way_o,
  output logic [ENT_W-1:0]      ent_o
);

  rmw_st_e            state_q, state_d;
  logic [IDX_W-1:0]   idx_q, idx_d;
  logic               way_q, way_d;
  logic [ENT_W-1:0]   mask_q, mask_d;
  logic [ENT_W-1:0]   data_q, data_d;
  logic [ENT_W-1:0]   merged_q, merged_d;

  always_comb begin
    state_d  = state_q;
    idx_d    = idx_q;
    way_d    = way_q;
    mask_d   = mask_q;
    data_d   = data_q;
    merged_d = merged_q;
    case (state_q)
      RMW_IDLE: begin
        if (start_i) begin
          state_d = RMW_READ;
          idx_d   = idx_i;
          way_d   = way_i;
          mask_d  = mask_i;
          data_d  = data_i;
        end
      end
      RMW_READ: begin
        merged_d = (old_ent_i[way_q] & ~mask_q) | (data_q & mask_q);
        state_d  = RMW_WRITE;
      end
      RMW_WRITE: state_d = RMW_IDLE;
      default:   state_d = RMW_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= RMW_IDLE;
      idx_q    <= '0;
      way_q    <= 1'b0;
      mask_q   <= '0;
      data_q   <= '0;
      merged_q <= '0;
    end else begin
      state_q  <= state_d;
      idx_q    <= idx_d;
      way_q    <= way_d;
      mask_q   <= mask_d;
      data_q   <= data_d;
      merged_q <= merged_d;
    end
  end

  assign busy_o     = (state_q != RMW_IDLE);
  assign rd_phase_o = (state_q == RMW_READ);
  assign wr_phase_o = (state_q == RMW_WRITE);
  assign idx_o      = idx_q;
  assign way_o      = way_q;
  assign ent_o      = merged_q;

  // R6
  read_then_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == RMW_READ) |=> (state_q == RMW_WRITE));

  // R6
  write_then_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == RMW_WRITE) |=> (state_q == RMW_IDLE));

endmodule

// File: rtl/tag_store_2way.sv
module tag_store_2way
  import tagp_pkg::*;
#(
  parameter int SETS   = DEF_SETS,
  parameter int TAG_W  = DEF_TAG_W,
  parameter int STAT_W = DEF_STAT_W,
  localparam int ENT_W = TAG_W + STAT_W + 1,
  localparam int IDX_W = $clog2(SETS),
  localparam int SEL_W = $clog2(ENT_W + 2)
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic             ready,
  input  logic             lk_en,
  input  logic [IDX_W-1:0] lk_idx,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic             wr_way,
  input  logic [ENT_W-1:0] wr_ent,
  input  logic             lru_we,
  input  logic [IDX_W-1:0] lru_idx,
  input  logic             lru_val,
  input  logic             pu_en,
  input  logic [IDX_W-1:0] pu_idx,
  input  logic             pu_way,
  input  logic [ENT_W-1:0] pu_mask,
  input  logic [ENT_W-1:0] pu_data,
  input  logic             tst_flip,
  input  logic [IDX_W-1:0] tst_idx,
  input  logic             tst_way,
  input  logic [SEL_W-1:0] tst_bit,
  output logic             rd_valid,
  output logic [ENT_W-1:0] rd_ent0,
  output logic [ENT_W-1:0] rd_ent1,
  output logic             rd_lru,
  output logic             perr_n
);

  // Reset: asserted asynchronously, released through two flops.
  logic [1:0] rst_sync_q;
  logic       rst_ni;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_ni = rst_sync_q[1];

  // Request qualification.
  logic busy, rmw_rd, rmw_wr, rmw_way;
  logic [IDX_W-1:0] rmw_idx;
  logic [ENT_W-1:0] rmw_ent;
  logic lk_go, wr_go, lru_go, pu_go, set_read;

  assign ready  = ~busy;
  assign lk_go  = ready & lk_en;
  assign wr_go  = ready & wr_en;
  assign lru_go = ready & lru_we;
  assign pu_go  = ready & pu_en & ~wr_en;   // a full write wins the cycle

  // Storage read and write muxing.
  logic [IDX_W-1:0]      arr_rd_idx;
  logic [1:0][ENT_W-1:0] arr_ent;
  logic [1:0]            arr_par;
  logic                  arr_lru;
  logic                  a_we, a_way, a_par;
  logic [IDX_W-1:0]      a_idx;
  logic [ENT_W-1:0]      a_ent;

  assign arr_rd_idx = rmw_rd ? rmw_idx : lk_idx;
  assign set_read   = lk_go | rmw_rd;
  assign a_we       = wr_go | rmw_wr;
  assign a_idx      = rmw_wr ? rmw_idx : wr_idx;
  assign a_way      = rmw_wr ? rmw_way : wr_way;
  assign a_ent      = rmw_wr ? rmw_ent : wr_ent;

  tag_parity_gen #(.W(ENT_W)) u_wgen (.data_i(a_ent), .par_o(a_par));

  tag_set_array #(.SETS(SETS), .ENT_W(ENT_W), .IDX_W(IDX_W), .SEL_W(SEL_W)) u_array (
    .clk      (clk),
    .rst_n    (rst_ni),
    .rd_idx   (arr_rd_idx),
    .rd_ent   (arr_ent),
    .rd_par   (arr_par),
    .rd_lru   (arr_lru),
    .we       (a_we),
    .w_idx    (a_idx),
    .w_way    (a_way),
    .w_ent    (a_ent),
    .w_par    (a_par),
    .lru_we   (lru_go),
    .lru_idx  (lru_idx),
    .lru_val  (lru_val),
    .flip_en  (tst_flip),
    .flip_idx (tst_idx),
    .flip_way (tst_way),
    .flip_sel (tst_bit)
  );

  tag_rmw_ctrl #(.IDX_W(IDX_W), .ENT_W(ENT_W)) u_rmw (
    .clk        (clk),
    .rst_n      (rst_ni),
    .start_i    (pu_go),
    .idx_i      (pu_idx),
    .way_i      (pu_way),
    .mask_i     (pu_mask),
    .data_i     (pu_data),
    .old_ent_i  (arr_ent),
    .busy_o     (busy),
    .rd_phase_o (rmw_rd),
    .wr_phase_o (rmw_wr),
    .idx_o      (rmw_idx),
    .way_o      (rmw_way),
    .ent_o      (rmw_ent)
  );

  // Parity regeneration and compare, outside the storage.
  logic [1:0] par_calc, mism;
  for (genvar w = 0; w < 2; w++) begin : g_chk
    tag_parity_gen #(.W(ENT_W)) u_chk (.data_i(arr_ent[w]), .par_o(par_calc[w]));
    assign mism[w] = par_calc[w] ^ arr_par[w];
  end

  // Output registers.
  logic                  rd_valid_q, rd_valid_d;
  logic [1:0][ENT_W-1:0] rd_ent_q, rd_ent_d;
  logic                  rd_lru_q, rd_lru_d;
  logic                  perr_n_q, perr_n_d;

  always_comb begin
    rd_valid_d = lk_go;
    rd_ent_d   = lk_go ? arr_ent : rd_ent_q;
    rd_lru_d   = lk_go ? arr_lru : rd_lru_q;
    perr_n_d   = set_read ? ~(|mism) : perr_n_q;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_valid_q <= 1'b0;
      rd_ent_q   <= '0;
      rd_lru_q   <= 1'b0;
      perr_n_q   <= 1'b1;
    end else begin
      rd_valid_q <= rd_valid_d;
      rd_ent_q   <= rd_ent_d;
      rd_lru_q   <= rd_lru_d;
      perr_n_q   <= perr_n_d;
    end
  end

  assign rd_valid = rd_valid_q;
  assign rd_ent0  = rd_ent_q[0];
  assign rd_ent1  = rd_ent_q[1];
  assign rd_lru   = rd_lru_q;
  assign perr_n   = perr_n_q;

  // R2
  lookup_resp_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (lk_en && ready) |=> rd_valid);

  // R2
  resp_source_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    rd_valid |-> $past(lk_en && ready));

  // R3
  wr_parity_even_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    a_we |-> !(^{a_par, a_ent}));

  // R6
  ready_low_two_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    $fell(ready) |=> !ready);

  // R6
  ready_return_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (!ready && $past(!ready)) |=> ready);

  // R6
  ready_drop_cause_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    $fell(ready) |-> $past(pu_en && !wr_en));

  // R7
  perr_hold_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    !set_read |=> $stable(perr_n));

  // R10
  wr_beats_pu_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (ready && wr_en) |=> ready);

endmodule

// File: tb/tb_tag_store_2way.sv
module tb_tag_store_2way;

  localparam int SETS  = 16;
  localparam int ENT_W = 20;
  localparam int IDX_W = 4;
  localparam int SEL_W = 5;

  logic clk = 1'b0;
  always #4 clk = ~clk;   // 125 MHz

  logic             rst_n;
  logic             ready, lk_en, wr_en, wr_way, lru_we, lru_val, pu_en, pu_way;
  logic             tst_flip, tst_way, rd_valid, rd_lru, perr_n;
  logic [IDX_W-1:0] lk_idx, wr_idx, lru_idx, pu_idx, tst_idx;
  logic [ENT_W-1:0] wr_ent, pu_mask, pu_data, rd_ent0, rd_ent1;
  logic [SEL_W-1:0] tst_bit;

  tag_store_2way dut (
    .clk(clk), .rst_n(rst_n), .ready(ready),
    .lk_en(lk_en), .lk_idx(lk_idx),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_way(wr_way), .wr_ent(wr_ent),
    .lru_we(lru_we), .lru_idx(lru_idx), .lru_val(lru_val),
    .pu_en(pu_en), .pu_idx(pu_idx), .pu_way(pu_way), .pu_mask(pu_mask), .pu_data(pu_data),
    .tst_flip(tst_flip), .tst_idx(tst_idx), .tst_way(tst_way), .tst_bit(tst_bit),
    .rd_valid(rd_valid), .rd_ent0(rd_ent0), .rd_ent1(rd_ent1), .rd_lru(rd_lru),
    .perr_n(perr_n)
  );

  typedef struct packed {
    logic [ENT_W-1:0] e0;
    logic [ENT_W-1:0] e1;
    logic             lru;
    logic             pn;
  } item_t;

  item_t exp_q[$];
  string tag_q[$];

  logic [ENT_W-1:0] m_ent [SETS][2];
  logic             m_par [SETS][2];
  logic             m_lru [SETS];
  int               busy_cnt;
  int               pu_i, pu_w;
  logic [ENT_W-1:0] pu_m, pu_d, pu_merge;
  logic             exp_perr_n;
  int               n_cmp, n_bad;
  bit               mon_en, done;

  task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic set_bad(int i);
    return (^{m_par[i][0], m_ent[i][0]}) | (^{m_par[i][1], m_ent[i][1]});
  endfunction

  function automatic logic [ENT_W-1:0] pat(int i, int w);
    return ENT_W'(i * 40503 + w * 7919 + 13);
  endfunction

  task automatic clear_in();
    lk_en = 0; lk_idx = '0; wr_en = 0; wr_idx = '0; wr_way = 0; wr_ent = '0;
    lru_we = 0; lru_idx = '0; lru_val = 0; pu_en = 0; pu_idx = '0; pu_way = 0;
    pu_mask = '0; pu_data = '0; tst_flip = 0; tst_idx = '0; tst_way = 0; tst_bit = '0;
  endtask

  task automatic nxt();
    @(negedge clk);
    clear_in();
  endtask

  // Driver: called once per cycle after the inputs are set; updates the model.
  task automatic go(string tag);
    bit rdy;
    item_t it;
    rdy = (busy_cnt == 0);
    chk(tag, "ready", ready, rdy);
    chk(tag, "perr_n", perr_n, exp_perr_n);
    if (rdy) begin
      if (lk_en) begin
        it = '{e0: m_ent[lk_idx][0], e1: m_ent[lk_idx][1], lru: m_lru[lk_idx],
               pn: !set_bad(int'(lk_idx))};
        exp_q.push_back(it);
        tag_q.push_back(tag);
        exp_perr_n = it.pn;
      end
      if (wr_en) begin
        m_ent[wr_idx][wr_way] = wr_ent;
        m_par[wr_idx][wr_way] = ^wr_ent;
      end else if (pu_en) begin
        pu_i = int'(pu_idx); pu_w = int'(pu_way); pu_m = pu_mask; pu_d = pu_data;
        busy_cnt = 2;
      end
      if (lru_we) m_lru[lru_idx] = lru_val;
    end else if (busy_cnt == 2) begin
      exp_perr_n = !set_bad(pu_i);
      pu_merge = (m_ent[pu_i][pu_w] & ~pu_m) | (pu_d & pu_m);
      busy_cnt = 1;
    end else begin
      m_ent[pu_i][pu_w] = pu_merge;
      m_par[pu_i][pu_w] = ^pu_merge;
      busy_cnt = 0;
    end
    if (tst_flip) begin
      if (tst_bit == 5'd21)      m_lru[tst_idx] = ~m_lru[tst_idx];
      else if (tst_bit == 5'd20) m_par[tst_idx][tst_way] = ~m_par[tst_idx][tst_way];
      else m_ent[tst_idx][tst_way][tst_bit] = ~m_ent[tst_idx][tst_way][tst_bit];
    end
  endtask

  // Monitor: pops expected lookup results as rd_valid appears.
  always @(negedge clk) begin
    if (mon_en && rd_valid) begin
      if (exp_q.size() == 0) begin
        chk("R6", "unexpected rd_valid", 1, 0);
      end else begin
        item_t e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(t, "rd_ent0", rd_ent0, e.e0);
        chk(t, "rd_ent1", rd_ent1, e.e1);
        chk(t, "rd_lru", rd_lru, e.lru);
        chk(t, "lookup perr_n", perr_n, e.pn);
      end
    end
  end

  task automatic idle(string tag);
    nxt(); go(tag);
  endtask
  task automatic lk(int i, string tag);
    nxt(); lk_en = 1; lk_idx = IDX_W'(i); go(tag);
  endtask
  task automatic wr(int i, int w, logic [ENT_W-1:0] e, string tag);
    nxt(); wr_en = 1; wr_idx = IDX_W'(i); wr_way = w[0]; wr_ent = e; go(tag);
  endtask
  task automatic pu(int i, int w, logic [ENT_W-1:0] m, logic [ENT_W-1:0] d, string tag);
    nxt(); pu_en = 1; pu_idx = IDX_W'(i); pu_way = w[0]; pu_mask = m; pu_data = d; go(tag);
  endtask
  task automatic flip(int i, int w, int b, string tag);
    nxt(); tst_flip = 1; tst_idx = IDX_W'(i); tst_way = w[0]; tst_bit = SEL_W'(b); go(tag);
  endtask

  task automatic report();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL R2 watchdog: actual hung expected finished");
      report();
      $finish;
    end
  end

  initial begin
    n_cmp = 0; n_bad = 0; mon_en = 0; done = 0; busy_cnt = 0; exp_perr_n = 1;
    for (int s = 0; s < SETS; s++) begin
      m_lru[s] = 0;
      for (int w = 0; w < 2; w++) begin m_ent[s][w] = '0; m_par[s][w] = 0; end
    end
    clear_in();
    rst_n = 0;
    repeat (4) @(negedge clk);
    // R1: state during reset
    chk("R1", "perr_n in reset", perr_n, 1);
    chk("R1", "ready in reset", ready, 1);
    chk("R1", "rd_valid in reset", rd_valid, 0);
    rst_n = 1;
    repeat (3) @(negedge clk);
    mon_en = 1;

    // R1: all sets clear after reset
    for (int s = 0; s < SETS; s++) lk(s, "R1");
    idle("R1");

    // R3 / R2: distinct patterns in both ways, LRU varied
    for (int s = 0; s < SETS; s++) begin
      wr(s, 0, pat(s, 0), "R3");
      wr(s, 1, pat(s, 1), "R3");
    end
    nxt(); lru_we = 1; lru_idx = 4'd6; lru_val = 1; go("R8");
    for (int s = 0; s < SETS; s++) lk(s, "R2");
    lk(3, "R2"); lk(3, "R2");   // back-to-back lookups of one set
    idle("R2");

    // R4: lookup and write to the same set in one cycle
    nxt(); lk_en = 1; lk_idx = 4'd9; wr_en = 1; wr_idx = 4'd9; wr_way = 1; wr_ent = 20'hF0F0F;
    go("R4");
    lk(9, "R4");

    // R5: status-only, read-only-flag and mixed masks
    pu(2, 0, 20'h0001E, 20'h00014, "R5"); idle("R5"); idle("R5");
    lk(2, "R5");
    pu(2, 1, 20'h00001, 20'h00001, "R5"); idle("R5"); idle("R5");
    lk(2, "R5");
    pu(7, 1, 20'hFF00F, 20'h12345, "R5"); idle("R5"); idle("R5");
    lk(7, "R5");

    // R6: requests while busy are ignored
    pu(4, 0, 20'h0001E, 20'h0000A, "R6");
    nxt(); lk_en = 1; lk_idx = 4'd4; wr_en = 1; wr_idx = 4'd5; wr_ent = 20'h11111;
    lru_we = 1; lru_idx = 4'd5; lru_val = 1; go("R6");
    nxt(); pu_en = 1; pu_idx = 4'd5; pu_way = 1; pu_mask = '1; pu_data = '0; go("R6");
    idle("R6");
    lk(5, "R6"); lk(4, "R6");
    idle("R6");

    // R7: entry-bit and parity-bit corruption, hold and recovery
    flip(3, 1, 7, "R7");
    lk(3, "R7");
    idle("R7"); idle("R7");
    lk(0, "R7");
    flip(11, 0, 20, "R7");
    lk(11, "R7");
    wr(11, 0, 20'h0BEEF, "R7");
    lk(11, "R7");

    // R8: LRU flip and write never raise an error
    flip(12, 0, 21, "R8");
    lk(12, "R8");
    nxt(); lru_we = 1; lru_idx = 4'd12; lru_val = 0; go("R8");
    lk(12, "R8");

    // R9: partial update of a corrupted way reports then heals it
    flip(5, 0, 3, "R9");
    pu(5, 0, 20'h0001E, 20'h00006, "R9"); idle("R9"); idle("R9");
    lk(5, "R9");

    // R10: full write and partial request in the same cycle
    nxt(); wr_en = 1; wr_idx = 4'd13; wr_way = 0; wr_ent = 20'hABCDE;
    pu_en = 1; pu_idx = 4'd13; pu_way = 0; pu_mask = '1; pu_data = 20'h00000; go("R10");
    idle("R10");
    lk(13, "R10");

    repeat (3) idle("R2");
    chk("R2", "pending lookups", exp_q.size(), 0);
    done = 1;
    report();
    $finish;
  end

endmodule